// File: doc/BRIEF.md
# Two-Channel Crossing Interval Timer

This block measures the time between two threshold crossings of a sampled waveform. Each of its two channels receives a one-bit comparator result and takes one sample of it per strobe pulse. A channel is set up with a crossing count and a polarity. From the start of an acquisition it numbers the strobes, counts only the crossings of the chosen polarity, and records the sample index at which the selected crossing occurs.

When both channels have recorded an index, the block subtracts the first index from the second. It multiplies that signed difference by a programmed sampling interval, so the result is an elapsed time in interval units. An acquisition ends after a programmed record length of samples. A channel that has not found its crossing by then reports a miss.

Configuration uses a small register port with an address, a write strobe and write data. Readback is a combinational read of the addressed register. The status flags and the timing result are also brought out directly as ports.

Top module: `xing_timer`

## Requirements
- R1: After reset, every config register, both captured indices and all status flags read as zero, and `time_valid` is low.
- R2: Writing with `cfg_we` stores data at `cfg_addr`, and `rd_addr` reads it back. Address 0 holds channel 0 setup and address 1 holds channel 1 setup: bits [7:0] are the crossing count and bit 8 is the polarity (1 = rising, 0 = falling); higher bits are dropped. Address 2 holds the record length and address 3 holds the sampling interval. Addresses 4 and 5 read the captured index of channel 0 and channel 1. Address 6 reads the status as {miss1, miss0, done1, done0} in bits [3:0].
- R3: The first strobe after `acq_start` has sample index 0, and each later strobe adds one. A crossing is a change of the comparator bit from its value at the previous strobe of the same acquisition, so no crossing can occur at index 0.
- R4: A channel sets its done flag and captures the current sample index on the strobe that carries its Nth crossing of the chosen polarity. Both are visible in the clock cycle after that strobe.
- R5: Crossings of the other polarity are not counted.
- R6: Once done is set, the captured index and the done flag stay unchanged, whatever crossings follow, until the next `acq_start`.
- R7: The acquisition ends on the strobe with index record length minus 1. A channel still searching at that point sets miss instead of done, unless its crossing falls on that last strobe. Done and miss are never set together.
- R8: A channel whose crossing count is zero sets miss in the cycle after `acq_start`.
- R9: `acq_start` clears done, miss and the crossing counts and restarts the index. A strobe in the same cycle as `acq_start` is not sampled.
- R10: `time_out` = (index1 − index0) × interval, as a signed value 2·IDX_W+2 bits wide. `time_valid` is high exactly when both channels are done.
- R11: Strobes before the first `acq_start`, or after an acquisition has ended, have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acq_start | input | 1 | Starts a new acquisition (one-cycle pulse) |
| strobe | input | 1 | Sample pulse; samples `cmp` while an acquisition runs |
| cmp | input | 2 | Comparator bit per channel (bit 0 = channel 0) |
| cfg_we | input | 1 | Register write enable |
| cfg_addr | input | 3 | Register write address |
| cfg_wdata | input | IDX_W | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | IDX_W | Read data for `rd_addr` |
| time_out | output | 2*IDX_W+2 | Signed elapsed time |
| time_valid | output | 1 | Both channels done |
| done_o | output | 2 | Per-channel crossing-found flags |
| miss_o | output | 2 | Per-channel not-found flags |

## Verification
A strobe presented before a rising edge produces its done, miss and index changes in the cycle after that edge. `time_out` and `time_valid` follow combinationally from those registers, and `rd_data` follows combinationally from `rd_addr`. The bench therefore drives every input at a falling edge and reads every result at the next falling edge, which is half a period after the one register stage. Miss after a zero crossing count appears one cycle after the `acq_start` pulse, and the bench checks it at that same falling edge.

// File: rtl/xing_timer.sv
module xing_timer #(
  parameter int IDX_W = 16,
  parameter int TN_W  = 8,
  localparam int OUT_W = 2*IDX_W + 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    acq_start,
  input  logic                    strobe,
  input  logic [1:0]              cmp,
  input  logic                    cfg_we,
  input  logic [2:0]              cfg_addr,
  input  logic [IDX_W-1:0]        cfg_wdata,
  input  logic [2:0]              rd_addr,
  output logic [IDX_W-1:0]        rd_data,
  output logic signed [OUT_W-1:0] time_out,
  output logic                    time_valid,
  output logic [1:0]              done_o,
  output logic [1:0]              miss_o
);

  logic [TN_W:0]      cfg [2];
  logic [IDX_W-1:0]   rec_len, interval, scnt;
  logic [IDX_W-1:0]   idx [2];
  logic [TN_W-1:0]    hits [2];
  logic [1:0]         done, miss, prev, edge_ok, found;
  logic               armed, seen;

  wire take = strobe & armed & ~acq_start;
  wire last = take && (scnt == rec_len - 1'b1);

  always_comb begin
    for (int c = 0; c < 2; c++) begin
      edge_ok[c] = take && seen && !done[c] && !miss[c] &&
                   (cmp[c] != prev[c]) && (cmp[c] == cfg[c][TN_W]);
      found[c]   = edge_ok[c] && ((hits[c] + 1'b1) == cfg[c][TN_W-1:0]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg[0] <= '0; cfg[1] <= '0;
      rec_len <= '0; interval <= '0; scnt <= '0;
      idx[0] <= '0; idx[1] <= '0;
      hits[0] <= '0; hits[1] <= '0;
      done <= '0; miss <= '0; prev <= '0;
      armed <= 1'b0; seen <= 1'b0;
    end else begin
      if (cfg_we) begin
        case (cfg_addr)
          3'd0: cfg[0] <= cfg_wdata[TN_W:0];
          3'd1: cfg[1] <= cfg_wdata[TN_W:0];
          3'd2: rec_len <= cfg_wdata;
          3'd3: interval <= cfg_wdata;
          default: ;
        endcase
      end
      if (acq_start) begin
        armed <= 1'b1;
        seen  <= 1'b0;
        scnt  <= '0;
        for (int c = 0; c < 2; c++) begin
          done[c] <= 1'b0;
          miss[c] <= (cfg[c][TN_W-1:0] == '0);
          hits[c] <= '0;
        end
      end else if (take) begin
        scnt <= scnt + 1'b1;
        seen <= 1'b1;
        prev <= cmp;
        if (last) armed <= 1'b0;
        for (int c = 0; c < 2; c++) begin
          if (edge_ok[c]) hits[c] <= hits[c] + 1'b1;
          if (found[c]) begin
            done[c] <= 1'b1;
            idx[c]  <= scnt;
          end else if (last && !done[c]) begin
            miss[c] <= 1'b1;
          end
        end
      end
    end
  end

  wire signed [IDX_W:0] diff = $signed({1'b0, idx[1]}) - $signed({1'b0, idx[0]});
  assign time_out   = OUT_W'(diff) * OUT_W'($signed({1'b0, interval}));
  assign time_valid = &done;
  assign done_o     = done;
  assign miss_o     = miss;

  always_comb begin
    case (rd_addr)
      3'd0:    rd_data = IDX_W'(cfg[0]);
      3'd1:    rd_data = IDX_W'(cfg[1]);
      3'd2:    rd_data = rec_len;
      3'd3:    rd_data = interval;
      3'd4:    rd_data = idx[0];
      3'd5:    rd_data = idx[1];
      3'd6:    rd_data = IDX_W'({miss, done});
      default: rd_data = '0;
    endcase
  end

endmodule

module xing_timer_chk #(
  parameter int IDX_W = 16,
  parameter int TN_W  = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             acq_start,
  input logic             strobe,
  input logic [TN_W-1:0]  tn0,
  input logic [1:0]       done,
  input logic [1:0]       miss,
  input logic [IDX_W-1:0] idx0,
  input logic [IDX_W-1:0] idx1
);

  assert_found_on_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done[0]) |-> $past(strobe));

  assert_frozen_idx0_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done[0] && !acq_start) |=> $stable(idx0));

  assert_frozen_idx1_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done[1] && !acq_start) |=> $stable(idx1));

  assert_done_miss_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done & miss) == 2'b00);

  assert_zero_count_miss_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (acq_start && tn0 == '0) |=> miss[0]);

  assert_start_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    acq_start |=> done == 2'b00);

endmodule

bind xing_timer xing_timer_chk #(.IDX_W(IDX_W), .TN_W(TN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .acq_start(acq_start), .strobe(strobe),
  .tn0(cfg[0][TN_W-1:0]), .done(done), .miss(miss),
  .idx0(idx[0]), .idx1(idx[1])
);

// File: tb/tb_xing_timer.sv
`timescale 1ns/1ps
module tb_xing_timer;
  localparam int IDX_W = 16;
  localparam int OUT_W = 2*IDX_W + 2;

  logic clk = 0, rst_n = 0, acq_start = 0, strobe = 0, cfg_we = 0;
  logic [1:0] cmp = '0;
  logic [2:0] cfg_addr = '0, rd_addr = '0;
  logic [IDX_W-1:0] cfg_wdata = '0, rd_data;
  logic signed [OUT_W-1:0] time_out;
  logic time_valid;
  logic [1:0] done_o, miss_o;

  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  xing_timer dut (
    .clk(clk), .rst_n(rst_n), .acq_start(acq_start), .strobe(strobe), .cmp(cmp),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .rd_addr(rd_addr), .rd_data(rd_data), .time_out(time_out),
    .time_valid(time_valid), .done_o(done_o), .miss_o(miss_o)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [IDX_W-1:0] d);
    @(negedge clk); cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [IDX_W-1:0] d);
    rd_addr = a; #1; d = rd_data;
  endtask

  task automatic start(input logic with_strobe);
    @(negedge clk); acq_start = 1; strobe = with_strobe; cmp = '0;
    @(negedge clk); acq_start = 0; strobe = 0;
  endtask

  task automatic run(input logic [31:0] a, input logic [31:0] b, input int from, input int upto);
    for (int i = from; i <= upto; i++) begin
      @(negedge clk); strobe = 1; cmp = {b[i], a[i]};
      @(negedge clk); strobe = 0;
    end
  endtask

  task automatic t_reset;
    logic [IDX_W-1:0] d;
    for (int a = 0; a < 7; a++) begin
      rd(3'(a), d); chk("R1 reg", d, 0);
    end
    chk("R1 time_valid", time_valid, 0);
  endtask

  task automatic t_regs;
    logic [IDX_W-1:0] d;
    wr(0, 16'hFFFF); rd(0, d); chk("R2 ch0 setup masked", d, 16'h01FF);
    wr(1, 16'h0123); rd(1, d); chk("R2 ch1 setup", d, 16'h0123);
    wr(2, 16'd20);   rd(2, d); chk("R2 record length", d, 20);
    wr(3, 16'd7);    rd(3, d); chk("R2 interval", d, 7);
  endtask

  task automatic t_before_start;
    logic [IDX_W-1:0] d;
    wr(0, 16'h0101); wr(1, 16'h0101);
    run(32'h5, 32'hA, 0, 3);
    rd(6, d); chk("R11 status unchanged", d, 0);
    rd(4, d); chk("R11 idx0 unchanged", d, 0);
  endtask

  task automatic t_first_sample;
    logic [IDX_W-1:0] d;
    start(0);
    run(32'hB, 32'h4, 0, 3);
    rd(4, d); chk("R3 no crossing at index 0", d, 3);
    rd(5, d); chk("R3 idx1", d, 2);
    chk("R10 negative time", time_out, -7);
    chk("R10 valid", time_valid, 1);
  endtask

  task automatic t_basic;
    logic [IDX_W-1:0] d;
    wr(0, 16'h0102); wr(1, 16'h0001); wr(2, 16'd20); wr(3, 16'd10);
    start(0);
    run(32'h6A, 32'h3F, 0, 3);
    chk("R4 done0 after 2nd rise", done_o, 2'b01);
    chk("R10 not valid with one channel", time_valid, 0);
    run(32'h6A, 32'h3F, 4, 6);
    rd(4, d); chk("R6 idx0 frozen", d, 3);
    rd(5, d); chk("R4 idx1 falling", d, 6);
    rd(6, d); chk("R4 status both done", d, 4'b0011);
    chk("R10 positive time", time_out, 30);
  endtask

  task automatic t_polarity;
    logic [IDX_W-1:0] d;
    wr(0, 16'h0101); wr(1, 16'h0002);
    start(0);
    run(32'h9, 32'h5, 0, 3);
    rd(4, d); chk("R5 falling ignored ch0", d, 3);
    rd(5, d); chk("R5 rising ignored ch1", d, 3);
    chk("R10 zero difference", time_out, 0);
  endtask

  task automatic t_miss;
    logic [IDX_W-1:0] d;
    wr(0, 16'h0103); wr(1, 16'h0101); wr(2, 16'd5);
    start(0);
    run(32'hA, 32'h10, 0, 3);
    rd(6, d); chk("R7 no miss before end", d, 0);
    run(32'hA, 32'h10, 4, 4);
    rd(6, d); chk("R7 miss0 and last-index done1", d, 4'b0110);
    rd(5, d); chk("R7 idx1 at last", d, 4);
    chk("R10 invalid on miss", time_valid, 0);
    run(32'hA0, 32'h0, 5, 7);
    rd(6, d); chk("R11 ignored after end", d, 4'b0110);
  endtask

  task automatic t_zero_count;
    wr(0, 16'h0100); wr(2, 16'd20);
    start(0);
    chk("R8 miss0 immediate", miss_o, 2'b01);
    chk("R8 done clear", done_o, 2'b00);
  endtask

  task automatic t_restart;
    logic [IDX_W-1:0] d;
    wr(0, 16'h0101);
    start(1);
    rd(6, d); chk("R9 status cleared", d, 0);
    run(32'h5, 32'h0, 0, 2);
    rd(4, d); chk("R9 coincident strobe not sampled", d, 2);
  endtask

  task automatic finish_run;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_before_start();
    t_first_sample();
    t_basic();
    t_polarity();
    t_miss();
    t_zero_count();
    t_restart();
    finish_run();
  end
endmodule